// File: doc/BRIEF.md
# ADPCM Codec Request and Configuration Controller

This block sits in front of a 256-channel ADPCM arithmetic engine. It takes one operation request at a time. A request is either an encode (a PCM sample in, an ADPCM code out) or a decode (an ADPCM code in, a PCM sample out). For each accepted request it works out which companding law, which bit-inversion choice and which ADPCM word size apply. It hands the request to the engine with a one-cycle start pulse, follows the engine's two completion pulses, and presents the result on registered outputs.

The request side is a valid/ready pair. `req_start` is the valid, and `busy` low is the ready. A request is taken on a rising edge where `req_start` is high and `busy` is low. While `busy` is high, any request is dropped rather than held, so the requester must keep `req_start` asserted (or assert it again) until it sees the request taken. The result side has no back-pressure: `out_valid` is a single-cycle pulse and the consumer must take the data in that cycle.

The mode pin `duplex_mode` is meant to be static. In duplex mode the lower half of the channel space encodes and the upper half decodes, and the two directions read separate configuration fields. In flexible mode any channel may do either operation, and both directions share one field set.

Top module: `adpcm_req_ctrl`

## Requirements
- R1: After reset, `busy`, `err_pulse`, `eng_start` and `out_valid` are 0, and both `enc_flag` and `dec_flag` are 1.
- R2: A request is taken on a rising edge with `req_start`=1 and `busy`=0 (and no R8 mismatch). From the next cycle `busy` is 1. In that next cycle `eng_start` is 1 for exactly one cycle, and `eng_encode`, `eng_chan`, `eng_std726`, `eng_pcm` and `eng_code` show the values captured at the taking edge.
- R3: `req_start` asserted while `busy`=1 is dropped. No second `eng_start` occurs, the engine-side values stay as captured, and the result reports the original channel.
- R4: For an encode, `enc_flag` is 0 from the cycle after the taking edge until the result cycle, and `dec_flag` stays 1. For a decode the two roles swap. Both flags are 1 again in the cycle `out_valid` is 1.
- R5: The controller advances only on an `eng_upd_done` pulse followed by an `eng_res_valid` pulse. In the cycle after `eng_res_valid`, `out_valid` is 1 and `busy` is 0, and a new request can be taken in that same cycle.
- R6: In duplex mode (`duplex_mode`=1), an encode takes its settings from `cfg_word` as follows: bit 7 sets the law (1 = A-law, 0 = µ-law), bit 6 sets inversion, and bits 5:4 set the word size, where codes 0, 1, 2, 3 give 2, 3, 4, 5 bits. These are captured at the taking edge, and later changes to `cfg_word` have no effect on the running operation.
- R7: A decode in duplex mode, and every operation in flexible mode (`duplex_mode`=0), take their settings from `cfg_word` bit 3 (law), bit 2 (inversion) and bits 1:0 (word size, coded as in R6).
- R8: In duplex mode, channels with `req_chan[7]`=0 may only encode and channels with `req_chan[7]`=1 may only decode. A request that breaks this gives `err_pulse`=1 for exactly one cycle, after which `busy` stays 0, both flags stay 1 and no `eng_start` is issued.
- R9: For an encode, `out_code` is `eng_res_data[4:0]` with every bit at or above the resolved word size forced to 0, and `out_pcm` is 0. For a decode, `out_pcm` is `eng_res_data` and `out_code` is 0. `out_encode` and `out_chan` echo the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| duplex_mode | input | 1 | 1 = duplex channel split, 0 = flexible |
| cfg_word | input | 8 | Law, inversion and word-size settings |
| req_start | input | 1 | Request valid |
| req_encode | input | 1 | 1 = encode, 0 = decode |
| req_chan | input | 8 | Channel number |
| req_std726 | input | 1 | Standard select, passed through to the engine |
| req_pcm | input | 8 | PCM sample for an encode |
| req_code | input | 5 | ADPCM code for a decode |
| busy | output | 1 | Operation in progress (request not ready) |
| err_pulse | output | 1 | Duplex channel/direction mismatch |
| enc_flag | output | 1 | Encode status, low while an encode runs |
| dec_flag | output | 1 | Decode status, low while a decode runs |
| eng_start | output | 1 | One-cycle start to the engine |
| eng_encode | output | 1 | Captured direction |
| eng_chan | output | 8 | Captured channel |
| eng_std726 | output | 1 | Captured standard select |
| eng_alaw | output | 1 | Resolved law |
| eng_invert | output | 1 | Resolved inversion |
| eng_wsize | output | 3 | Resolved word size, 2 to 5 |
| eng_pcm | output | 8 | Captured PCM sample |
| eng_code | output | 5 | Captured ADPCM code |
| eng_upd_done | input | 1 | Engine predictor update finished |
| eng_res_valid | input | 1 | Engine result available |
| eng_res_data | input | 8 | Engine result |
| out_valid | output | 1 | Result pulse |
| out_encode | output | 1 | Direction of the result |
| out_chan | output | 8 | Channel of the result |
| out_code | output | 5 | Masked ADPCM code |
| out_pcm | output | 8 | Decoded PCM sample |

## Verification
A stuck or mis-sequenced operation state shows up within one cycle of the taking edge. It appears as a missing or repeated `eng_start`, as a status flag that fails to drop or drops for the wrong direction, or as `busy` staying high after the result pulse. A wrong field choice in the configuration resolver shows on `eng_alaw`, `eng_invert` and `eng_wsize` in the start cycle, and one result later as extra upper bits in `out_code`. A request wrongly taken while busy shows as an extra start pulse and a result carrying the wrong channel.

// File: rtl/adpcm_ctrl_pkg.sv
package adpcm_ctrl_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LAUNCH, ST_UPD, ST_RES} op_state_t;

  typedef struct packed {
    logic       alaw;
    logic       invert;
    logic [2:0] wsize;
  } law_cfg_t;

  localparam int unsigned MIN_WSIZE = 2;
endpackage

// File: rtl/codec_cfg_resolve.sv
module codec_cfg_resolve
  import adpcm_ctrl_pkg::*;
#(
  parameter int unsigned CFG_W = 8
) (
  input  logic             duplex,
  input  logic             is_encode,
  input  logic [CFG_W-1:0] cfg,
  output law_cfg_t         res
);
  localparam int unsigned HALF = CFG_W / 2;

  logic [HALF-1:0] field;

  // Upper nibble only for duplex encodes; all else uses the lower nibble.
  always_comb begin
    if (duplex && is_encode) field = cfg[CFG_W-1:HALF];
    else                     field = cfg[HALF-1:0];
    res.alaw   = field[HALF-1];
    res.invert = field[HALF-2];
    res.wsize  = 3'(field[1:0]) + 3'(MIN_WSIZE);
  end
endmodule

// File: rtl/codec_op_fsm.sv
module codec_op_fsm
  import adpcm_ctrl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic is_encode,
  input  logic upd_done,
  input  logic res_valid,
  output logic busy,
  output logic eng_start,
  output logic enc_flag,
  output logic dec_flag,
  output logic finish
);
  op_state_t state_q;
  logic      op_enc_q;

  assign busy      = (state_q != ST_IDLE);
  assign eng_start = (state_q == ST_LAUNCH);
  assign finish    = (state_q == ST_RES) && res_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      op_enc_q <= 1'b0;
      enc_flag <= 1'b1;
      dec_flag <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q  <= ST_LAUNCH;
          op_enc_q <= is_encode;
          if (is_encode) enc_flag <= 1'b0;
          else           dec_flag <= 1'b0;
        end
        ST_LAUNCH: state_q <= ST_UPD;
        ST_UPD:    if (upd_done) state_q <= ST_RES;
        ST_RES: if (res_valid) begin
          state_q <= ST_IDLE;
          if (op_enc_q) enc_flag <= 1'b1;
          else          dec_flag <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  property eng_start_single_p;
    @(posedge clk) disable iff (!rst_n) eng_start |=> !eng_start;
  endproperty
  eng_start_single_chk: assert property (eng_start_single_p);

  // R4
  property flag_needs_busy_p;
    @(posedge clk) disable iff (!rst_n) (!enc_flag || !dec_flag) |-> busy;
  endproperty
  flag_needs_busy_chk: assert property (flag_needs_busy_p);

  // R4
  property one_flag_low_p;
    @(posedge clk) disable iff (!rst_n) !(!enc_flag && !dec_flag);
  endproperty
  one_flag_low_chk: assert property (one_flag_low_p);

  // R5
  property finish_releases_p;
    @(posedge clk) disable iff (!rst_n) finish |=> (!busy && enc_flag && dec_flag);
  endproperty
  finish_releases_chk: assert property (finish_releases_p);
endmodule

// File: rtl/codec_out_fmt.sv
module codec_out_fmt #(
  parameter int unsigned CODE_W = 5
) (
  input  logic [CODE_W-1:0] raw_code,
  input  logic [2:0]        wsize,
  output logic [CODE_W-1:0] code
);
  logic [CODE_W-1:0] keep;

  for (genvar i = 0; i < CODE_W; i++) begin : g_mask
    assign keep[i] = (32'(i) < 32'(wsize));
  end

  assign code = raw_code & keep;
endmodule

// File: rtl/adpcm_req_ctrl.sv
module adpcm_req_ctrl
  import adpcm_ctrl_pkg::*;
#(
  parameter int unsigned CHAN_W = 8,
  parameter int unsigned PCM_W  = 8,
  parameter int unsigned CODE_W = 5,
  parameter int unsigned CFG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              duplex_mode,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic              req_start,
  input  logic              req_encode,
  input  logic [CHAN_W-1:0] req_chan,
  input  logic              req_std726,
  input  logic [PCM_W-1:0]  req_pcm,
  input  logic [CODE_W-1:0] req_code,
  output logic              busy,
  output logic              err_pulse,
  output logic              enc_flag,
  output logic              dec_flag,
  output logic              eng_start,
  output logic              eng_encode,
  output logic [CHAN_W-1:0] eng_chan,
  output logic              eng_std726,
  output logic              eng_alaw,
  output logic              eng_invert,
  output logic [2:0]        eng_wsize,
  output logic [PCM_W-1:0]  eng_pcm,
  output logic [CODE_W-1:0] eng_code,
  input  logic              eng_upd_done,
  input  logic              eng_res_valid,
  input  logic [PCM_W-1:0]  eng_res_data,
  output logic              out_valid,
  output logic              out_encode,
  output logic [CHAN_W-1:0] out_chan,
  output logic [CODE_W-1:0] out_code,
  output logic [PCM_W-1:0]  out_pcm
);
  localparam int unsigned HALF_BIT = CHAN_W - 1;

  logic      try_take, half_bad, accept, finish;
  law_cfg_t  cfg_res, cfg_q;
  logic [CODE_W-1:0] fmt_code;

  assign try_take = req_start && !busy;
  // encode-only half has top channel bit 0
  assign half_bad = duplex_mode && (req_encode == req_chan[HALF_BIT]);
  assign accept   = try_take && !half_bad;

  codec_cfg_resolve #(.CFG_W(CFG_W)) u_resolve (
    .duplex    (duplex_mode),
    .is_encode (req_encode),
    .cfg       (cfg_word),
    .res       (cfg_res)
  );

  codec_op_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .is_encode (req_encode),
    .upd_done  (eng_upd_done),
    .res_valid (eng_res_valid),
    .busy      (busy),
    .eng_start (eng_start),
    .enc_flag  (enc_flag),
    .dec_flag  (dec_flag),
    .finish    (finish)
  );

  codec_out_fmt #(.CODE_W(CODE_W)) u_fmt (
    .raw_code (eng_res_data[CODE_W-1:0]),
    .wsize    (cfg_q.wsize),
    .code     (fmt_code)
  );

  assign eng_alaw   = cfg_q.alaw;
  assign eng_invert = cfg_q.invert;
  assign eng_wsize  = cfg_q.wsize;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_pulse  <= 1'b0;
      eng_encode <= 1'b0;
      eng_chan   <= '0;
      eng_std726 <= 1'b0;
      eng_pcm    <= '0;
      eng_code   <= '0;
      cfg_q      <= '{alaw: 1'b0, invert: 1'b0, wsize: 3'(MIN_WSIZE)};
    end else begin
      err_pulse <= try_take && half_bad;
      if (accept) begin
        eng_encode <= req_encode;
        eng_chan   <= req_chan;
        eng_std726 <= req_std726;
        eng_pcm    <= req_pcm;
        eng_code   <= req_code;
        cfg_q      <= cfg_res;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_encode <= 1'b0;
      out_chan   <= '0;
      out_code   <= '0;
      out_pcm    <= '0;
    end else begin
      out_valid <= finish;
      if (finish) begin
        out_encode <= eng_encode;
        out_chan   <= eng_chan;
        out_code   <= eng_encode ? fmt_code : '0;
        out_pcm    <= eng_encode ? '0 : eng_res_data;
      end
    end
  end

  // R3
  property hold_while_busy_p;
    @(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(eng_chan) && $stable(eng_encode) && $stable(cfg_q));
  endproperty
  hold_while_busy_chk: assert property (hold_while_busy_p);

  // R8
  property err_keeps_idle_p;
    @(posedge clk) disable iff (!rst_n) err_pulse |-> (!busy && enc_flag && dec_flag);
  endproperty
  err_keeps_idle_chk: assert property (err_keeps_idle_p);

  // R8
  property err_single_p;
    @(posedge clk) disable iff (!rst_n) (err_pulse && !req_start) |=> !err_pulse;
  endproperty
  err_single_chk: assert property (err_single_p);

  // R9
  property code_masked_p;
    @(posedge clk) disable iff (!rst_n)
      (out_valid && out_encode) |-> ((out_code >> cfg_q.wsize) == '0);
  endproperty
  code_masked_chk: assert property (code_masked_p);
endmodule

// File: tb/sim_adpcm_req_ctrl.sv
`timescale 1ns/1ps
module sim_adpcm_req_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       duplex_mode = 1'b0;
  logic [7:0] cfg_word = '0;
  logic       req_start = 1'b0, req_encode = 1'b0, req_std726 = 1'b0;
  logic [7:0] req_chan = '0, req_pcm = '0;
  logic [4:0] req_code = '0;
  logic       busy, err_pulse, enc_flag, dec_flag, eng_start, eng_encode;
  logic [7:0] eng_chan, eng_pcm;
  logic       eng_std726, eng_alaw, eng_invert;
  logic [2:0] eng_wsize;
  logic [4:0] eng_code;
  logic       eng_upd_done = 1'b0, eng_res_valid = 1'b0;
  logic [7:0] eng_res_data = '0;
  logic       out_valid, out_encode;
  logic [7:0] out_chan, out_pcm;
  logic [4:0] out_code;

  adpcm_req_ctrl u0 (.*);

  int checks = 0;
  int errors = 0;
  int starts = 0;
  int ops = 0;

  typedef struct packed {
    logic enc; logic [7:0] ch; logic std; logic [7:0] pcm; logic [4:0] code;
    logic alaw; logic inv; logic [2:0] ws;
  } eng_exp_t;
  typedef struct packed {
    logic enc; logic [7:0] ch; logic [4:0] code; logic [7:0] pcm;
  } out_exp_t;

  eng_exp_t eng_q[$];
  out_exp_t out_q[$];

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] stub_res(logic [7:0] ch);
    return {ch[3:0], ch[7:4]} ^ 8'h5B;
  endfunction

  // engine stub: checks the start-cycle values, then answers
  initial begin
    forever begin
      @(negedge clk);
      if (eng_start) begin
        eng_exp_t e, a;
        starts++;
        a = '{eng_encode, eng_chan, eng_std726, eng_pcm, eng_code, eng_alaw, eng_invert, eng_wsize};
        if (eng_q.size() == 0) check(1'b0, "R3 extra eng_start", 64'(a), 0);
        else begin
          e = eng_q.pop_front();
          // R2 R6 R7 captured and resolved values
          check(a == e, "R2/R6/R7 engine values", 64'(a), 64'(e));
        end
        repeat (2) @(negedge clk);
        eng_upd_done = 1'b1;
        @(negedge clk) eng_upd_done = 1'b0;
        @(negedge clk);
        eng_res_valid = 1'b1;
        eng_res_data  = stub_res(a.ch);
        @(negedge clk) eng_res_valid = 1'b0;
      end
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (out_valid) begin
        out_exp_t e, a;
        a = '{out_encode, out_chan, out_code, out_pcm};
        if (out_q.size() == 0) check(1'b0, "R9 unexpected out_valid", 64'(a), 0);
        else begin
          e = out_q.pop_front();
          check(a == e, "R9 R3 result", 64'(a), 64'(e));
          check(!busy && enc_flag && dec_flag, "R5 R4 release with result",
                64'({busy, enc_flag, dec_flag}), 64'b011);
        end
      end
    end
  end

  task automatic do_op(bit enc, logic [7:0] ch, logic [7:0] cfg, bit std,
                       logic [7:0] pcm, logic [4:0] code, bit poke);
    logic [3:0] f;
    logic [2:0] ws;
    logic [4:0] mask;
    f    = (duplex_mode && enc) ? cfg[7:4] : cfg[3:0];
    ws   = 3'(f[1:0]) + 3'd2;
    mask = 5'((6'd1 << ws) - 6'd1);
    eng_q.push_back('{enc, ch, std, pcm, code, f[3], f[2], ws});
    out_q.push_back('{enc, ch, enc ? (stub_res(ch)[4:0] & mask) : 5'd0,
                      enc ? 8'd0 : stub_res(ch)});
    ops++;
    @(negedge clk);
    while (busy) @(negedge clk);
    req_encode = enc; req_chan = ch; req_std726 = std;
    req_pcm = pcm; req_code = code; cfg_word = cfg; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    cfg_word  = ~cfg;  // R6: must not matter after capture
    check(busy == 1'b1, "R2 busy after take", 64'(busy), 1);
    // R4
    check(enc_flag == !enc && dec_flag == enc, "R4 flags after take",
          64'({enc_flag, dec_flag}), 64'({!enc, enc}));
    if (poke) begin
      req_encode = !enc; req_chan = ~ch; req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
      check(busy && enc_flag == !enc && dec_flag == enc, "R3 poke ignored",
            64'({busy, enc_flag, dec_flag}), 64'({1'b1, !enc, enc}));
    end
    while (busy) @(negedge clk);
    check(enc_flag && dec_flag, "R5 flags high after finish",
          64'({enc_flag, dec_flag}), 64'b11);
  endtask

  task automatic bad_req(bit enc, logic [7:0] ch);
    @(negedge clk);
    while (busy) @(negedge clk);
    req_encode = enc; req_chan = ch; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    // R8
    check(err_pulse && !busy && enc_flag && dec_flag, "R8 mismatch rejected",
          64'({err_pulse, busy, enc_flag, dec_flag}), 64'b1011);
    @(negedge clk);
    check(!err_pulse && !busy, "R8 single pulse", 64'({err_pulse, busy}), 0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(!busy && !err_pulse && !eng_start && !out_valid && enc_flag && dec_flag,
          "R1 reset state", 64'({busy, err_pulse, eng_start, out_valid, enc_flag, dec_flag}),
          64'b000011);

    // flexible mode: R7
    duplex_mode = 1'b0;
    do_op(1'b1, 8'd5,   8'h3E, 1'b1, 8'h12, 5'h00, 1'b0);
    do_op(1'b0, 8'd9,   8'hC1, 1'b0, 8'h00, 5'h1D, 1'b0);
    do_op(1'b0, 8'd200, 8'hF0, 1'b1, 8'h00, 5'h03, 1'b1);
    do_op(1'b1, 8'd140, 8'h0B, 1'b0, 8'hA7, 5'h00, 1'b1);

    // duplex mode: R6 R7
    duplex_mode = 1'b1;
    do_op(1'b1, 8'd10,  8'hB4, 1'b1, 8'h55, 5'h00, 1'b0);
    do_op(1'b0, 8'd130, 8'hB4, 1'b0, 8'h00, 5'h11, 1'b0);
    do_op(1'b1, 8'd127, 8'h40, 1'b0, 8'hFF, 5'h00, 1'b1);
    do_op(1'b1, 8'd0,   8'h2F, 1'b1, 8'h01, 5'h00, 1'b0);
    do_op(1'b0, 8'd255, 8'h03, 1'b1, 8'h00, 5'h1F, 1'b1);

    // R8 mismatches
    bad_req(1'b1, 8'd128);
    bad_req(1'b0, 8'd3);
    do_op(1'b1, 8'd77, 8'h90, 1'b0, 8'h3C, 5'h00, 1'b0);

    repeat (10) @(negedge clk);
    // R3 no extra starts
    check(starts == ops && eng_q.size() == 0 && out_q.size() == 0, "R3 start count",
          64'(starts), 64'(ops));
    summary();
  end
endmodule